// File: doc/BRIEF.md
# Watchdog Timer with Timed Disable Unlock

This block supervises software by counting ticks of a slow watchdog clock and raising a reset pulse when a programmable number of ticks passes without a kick from software. The tick arrives as a one-cycle strobe already brought into the system clock domain. Software picks one of eight timeout lengths, each twice the previous one. The longest is 128 times the shortest.

Software controls the block through an 8-bit control register. Turning the watchdog on is always allowed. Turning it off needs a short unlock: software first sets a change-enable bit, and that bit clears itself after four system clock cycles. A write that clears the enable bit counts only while the window is open. When the protected-mode input is high, the same window also guards changes to the timeout select.

Top module: `wdt_protected`

## Requirements
- R1: While reset is low, and on the cycle after reset, the control readback is 0x00 and the reset pulse output is low.
- R2: The readback is {3'b000, change-enable (bit 4), enable (bit 3), timeout select (bits 2..0)}. Bits 7..5 read as zero whatever was written to them. A write shows in the readback on the next cycle.
- R3: With select code c, the reset pulse goes high in the cycle after the tick that completes 2^(BASE_LOG2+c) ticks, counted from the last clear of the counter.
- R4: The counter only advances on cycles where the tick strobe is high and the enable bit is set. No pulse occurs while ticks are absent or while the watchdog is disabled.
- R5: A kick clears the counter. A kick in the same cycle as the completing tick suppresses the pulse, and the next full period is then counted from zero.
- R6: The reset pulse lasts exactly one cycle, and the next period is counted from zero.
- R7: Writing one to the enable bit is always accepted. Enabling a disabled watchdog starts counting from zero.
- R8: A write with the enable bit zero clears the enable bit only if change-enable was already one before that write. Otherwise the enable bit stays one.
- R9: Writing one to bit 4 makes change-enable read one for exactly UNLOCK_CYCLES (4) cycles, after which it reads zero. Writing zero to bit 4 does not close the window early.
- R10: When the protected-mode input is high and change-enable is zero, a write leaves the timeout select unchanged. When the input is low, or the window is open, the select takes the written value.
- R11: If a smaller select makes the current count reach or pass the new period, the pulse fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_mode | input | 1 | High: select changes need the unlock window |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| kick | input | 1 | Software kick, clears the timeout counter |
| wd_tick | input | 1 | One-cycle strobe per watchdog clock period |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
A register write appears in the readback one clock after the edge that takes it. Change-enable reads one at the four falling-edge samples after that edge and zero at the fifth. The reset pulse is high for the single cycle after the edge whose tick completes the period, so a kick or a select change takes effect from the next tick. The bench drives inputs on the falling edge and samples one falling edge per clock. A behavioural model steps on every rising edge, so each result is compared in exactly the cycle it is due. Directed checks count those edges explicitly for the window length, the period, the restart and the kick-versus-tick race.

// File: rtl/wdt_pkg.sv
// Package: shared types for the watchdog.
// Assumes the timeout select is three bits wide (eight codes).
package wdt_pkg;
    localparam int PSEL_W = 3;

    typedef struct packed {
        logic              chg_en;
        logic              en;
        logic [PSEL_W-1:0] psel;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
// Control register with a self-closing unlock window.
// Setting enable is always accepted. Clearing enable needs the window to be
// open already, and so does a select change when prot_mode is high.
// Assumes a single system clock and a synchronous active-low reset.
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter int UNLOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_mode,
    input  logic             wr_en,
    input  logic [4:0]       wr_data,
    output wdt_ctrl_t        ctrl
);
    localparam int WIN_W = $clog2(UNLOCK_CYCLES + 1);

    logic [WIN_W-1:0]  win_q;
    logic              en_q;
    logic [PSEL_W-1:0] psel_q;
    logic              win_open;
    logic              set_win;

    assign win_open = (win_q != '0);
    assign set_win  = wr_en && wr_data[4];

    // Unlock window: loaded on a bit-4 write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_q <= '0;
        else if (set_win) win_q <= WIN_W'(UNLOCK_CYCLES);
        else if (win_open) win_q <= win_q - WIN_W'(1);
    end

    // Enable bit: set freely, cleared only inside an open window.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else if (wr_en) begin
            if (wr_data[3])    en_q <= 1'b1;
            else if (win_open) en_q <= 1'b0;
        end
    end

    // Timeout select: guarded by the window only in protected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) psel_q <= '0;
        else if (wr_en && (!prot_mode || win_open)) psel_q <= wr_data[PSEL_W-1:0];
    end

    assign ctrl = '{chg_en: win_open, en: en_q, psel: psel_q};

    assert_guarded_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> $past(win_open));
    assert_window_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WIN_W'(1) && !set_win) |=> !ctrl.chg_en);
    assert_window_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.chg_en) |-> $past(set_win));
    assert_locked_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode && !win_open) |=> $stable(psel_q));
endmodule

// File: rtl/wdt_timeout.sv
// Timeout counter: counts watchdog ticks while enabled and raises a one-cycle
// fire pulse when the selected period (2^(BASE_LOG2+psel) ticks) is reached.
// Assumes wd_tick is already a single-cycle strobe in the clk domain.
module wdt_timeout
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    input  logic              kick,
    input  logic              tick,
    output logic              fire
);
    localparam int CNT_W = BASE_LOG2 + (1 << PSEL_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] period;
    logic             hit;
    logic             fire_q;

    assign period  = CNT_W'(1) << (CNT_W'(BASE_LOG2) + CNT_W'(psel));
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign hit     = en && tick && !kick && (cnt_inc >= period);

    // Tick counter: cleared by kick, by a timeout or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (kick || !en || hit)  cnt_q <= '0;
        else if (tick)                cnt_q <= cnt_inc;
    end

    // Registered fire pulse, one cycle per timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= hit;
    end

    assign fire = fire_q;

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0 && !fire_q));
    assert_fire_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(en && tick));
    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_protected.sv
// Top of the watchdog: control register plus timeout counter.
// Readback packs reserved zeros above the control fields.
// Assumes all inputs are synchronous to clk.
module wdt_protected
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2     = 14,
    parameter int UNLOCK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_mode,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       kick,
    input  logic       wd_tick,
    output logic       wdt_rst
);
    wdt_ctrl_t ctrl;
    logic      unused_rsvd;

    assign unused_rsvd = ^reg_wdata[7:5];

    wdt_ctrl_reg #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_mode (prot_mode),
        .wr_en     (reg_wr),
        .wr_data   (reg_wdata[4:0]),
        .ctrl      (ctrl)
    );

    wdt_timeout #(.BASE_LOG2(BASE_LOG2)) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.en),
        .psel  (ctrl.psel),
        .kick  (kick),
        .tick  (wd_tick),
        .fire  (wdt_rst)
    );

    // Readback: reserved bits forced to zero.
    always_comb begin
        reg_rdata = {3'b000, ctrl};
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 8'h00 && !wdt_rst));
endmodule

// File: tb/wdt_protected_bench.sv
module wdt_protected_bench;
    localparam int B_LOG2 = 2;
    localparam int UNLK   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_mode = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       kick = 1'b0;
    logic       wd_tick = 1'b0;
    logic       wdt_rst;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_win = 0;
    int m_cnt = 0;
    bit m_en = 1'b0;
    int m_psel = 0;
    bit m_rst = 1'b0;

    always #2.5 clk = ~clk;

    wdt_protected #(.BASE_LOG2(B_LOG2), .UNLOCK_CYCLES(UNLK)) u_wdt_protected (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kick(kick),
        .wd_tick(wd_tick), .wdt_rst(wdt_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    // Reference model advances on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = 0; m_cnt = 0; m_en = 0; m_psel = 0; m_rst = 0;
        end else begin
            bit open;
            bit fire;
            open = (m_win != 0);
            fire = m_en && wd_tick && !kick && (m_cnt + 1 >= (1 << (B_LOG2 + m_psel)));
            if (kick || !m_en || fire) m_cnt = 0;
            else if (wd_tick) m_cnt = m_cnt + 1;
            m_rst = fire;
            if (reg_wr && reg_wdata[4]) m_win = UNLK;
            else if (m_win > 0) m_win = m_win - 1;
            if (reg_wr) begin
                if (reg_wdata[3]) m_en = 1;
                else if (open) m_en = 0;
                if (!prot_mode || open) m_psel = int'(reg_wdata[2:0]);
            end
        end
    end

    // Compare against the model once per cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("MODEL R2 R9 R10 readback", 32'(reg_rdata),
                {24'h0, 3'b000, (m_win != 0), m_en, 3'(m_psel)});
            chk("MODEL R3 R5 R6 pulse", 32'(wdt_rst), 32'(m_rst));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int seen;
        @(negedge clk);
        repeat (3) step();
        chk("R1 rdata in reset", 32'(reg_rdata), 32'h0);
        chk("R1 pulse in reset", 32'(wdt_rst), 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 rdata after reset", 32'(reg_rdata), 32'h0);

        // R2: reserved bits dropped
        wr(8'hE5);
        chk("R2 reserved zero", 32'(reg_rdata), 32'h05);

        // R9: window length
        wr(8'h10);
        chk("R9 window c1", 32'(reg_rdata), 32'h10);
        for (int i = 0; i < UNLK - 1; i++) begin
            step();
            chk("R9 window open", 32'(reg_rdata), 32'h10);
        end
        step();
        chk("R9 window closed", 32'(reg_rdata), 32'h00);

        // R7 / R3 / R6: enable and count period 4
        wr(8'h08);
        chk("R7 enable accepted", 32'(reg_rdata), 32'h08);
        wd_tick = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 no early pulse", 32'(wdt_rst), 32'h0);
        end
        step();
        chk("R3 pulse at period", 32'(wdt_rst), 32'h1);
        step();
        chk("R6 pulse one cycle", 32'(wdt_rst), 32'h0);
        step(); step();
        chk("R6 restart quiet", 32'(wdt_rst), 32'h0);
        step();
        chk("R6 restart pulse", 32'(wdt_rst), 32'h1);

        // R5: kick on the completing tick
        step(); step(); step();
        kick = 1'b1;
        step();
        kick = 1'b0;
        chk("R5 kick suppresses", 32'(wdt_rst), 32'h0);
        step(); step(); step();
        chk("R5 count from zero", 32'(wdt_rst), 32'h0);
        step();
        chk("R5 pulse after full period", 32'(wdt_rst), 32'h1);

        // R4: no ticks, no pulse
        wd_tick = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (wdt_rst) seen++;
        end
        chk("R4 no pulse without ticks", 32'(seen), 32'h0);

        // R8: guarded disable
        wr(8'h00);
        chk("R8 disable ignored", 32'(reg_rdata), 32'h08);
        wr(8'h18);
        chk("R8 window opened", 32'(reg_rdata), 32'h18);
        wr(8'h00);
        chk("R8 disable accepted", 32'(reg_rdata), 32'h10);
        wd_tick = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (wdt_rst) seen++;
        end
        chk("R4 no pulse while disabled", 32'(seen), 32'h0);
        wd_tick = 1'b0;

        // R10: protected select
        prot_mode = 1'b1;
        wr(8'h0B);
        chk("R10 select locked", 32'(reg_rdata), 32'h08);
        wr(8'h10);
        chk("R10 window keeps select", 32'(reg_rdata), 32'h18);
        wr(8'h0B);
        chk("R10 select unlocked", 32'(reg_rdata), 32'h1B);
        prot_mode = 1'b0;
        repeat (5) step();
        chk("R9 window expired", 32'(reg_rdata), 32'h0B);
        wr(8'h0F);
        chk("R10 unprotected select", 32'(reg_rdata), 32'h0F);

        // R11: shrink the period below the count
        wd_tick = 1'b1;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (wdt_rst) seen++;
        end
        chk("R3 long period quiet", 32'(seen), 32'h0);
        wr(8'h08);
        chk("R11 no pulse on write edge", 32'(wdt_rst), 32'h0);
        step();
        chk("R11 pulse on next tick", 32'(wdt_rst), 32'h1);

        // Mixed traffic checked by the model
        for (int i = 0; i < 4000; i++) begin
            wd_tick   = ($urandom % 3) == 0;
            kick      = ($urandom % 200) == 0;
            prot_mode = ($urandom % 2) == 0;
            reg_wr    = ($urandom % 60) == 0;
            reg_wdata = 8'($urandom);
            step();
        end
        reg_wr = 1'b0;
        kick = 1'b0;
        wd_tick = 1'b0;
        step();
        finish_run();
    end
endmodule